// File: doc/BRIEF.md
# Prescaled Countdown Timer Bank

This block holds a bank of independent countdown timers behind a small byte-wide register bus. Each timer picks one of four time bases, all derived from the single reference clock by integer dividers that emit one-cycle tick enables. While a timer is enabled it decrements once per tick of its chosen base. When it expires it pulses its interrupt line for one reference cycle and reloads itself, so it runs periodically.

Even-indexed timers are 24 bits wide and odd-indexed timers are 32 bits wide. Software writes a reload value, then starts the timer by writing enable and restart together. It can watch progress through an observer register. That register returns either the raw down-count or its bitwise inverse, which reads as an up-count. Reading byte 0 of an observer latches the whole value, so the remaining bytes read back coherently.

Top module: `cdt_bank`

## Requirements
- R1: After reset every timer is disabled: control reads 0x00, clock select reads 0, the count register reads all ones within the timer's width, and the observer reads the same all-ones value.
- R2: Timers 0, 2 and 4 are 24 bits wide and timers 1, 3 and 5 are 32 bits wide. A write to byte 3 of a 24-bit timer's count register is dropped, and that byte reads 0x00 in both the count and observer registers.
- R3: Timer i's registers sit at byte address 8*i: control at +0, clock select at +1, and the count as little-endian bytes at +4..+7. Clock-select codes 0, 1, 2 and 3 choose tick dividers DIV_SLOW, DIV_MID, DIV_LOW and DIV_FAST. The tick of each base fires in the cycle its free-running counter (cleared by reset) reaches divider-1.
- R4: An enabled timer decrements on each tick of its selected base. On a tick while the count is 1, it reloads and raises its irq bit in the following cycle for exactly that cycle. A reload value of N therefore gives one pulse every N ticks.
- R5: Control bit 0 is enable and bit 1 is restart. Writing both as 1 loads the count register's value into the counter and the reload store on the next cycle. The restart bit reads back as 1 only in the cycle right after the write, then clears by itself.
- R6: Writing enable as 0 freezes the counter. Writing enable as 1 without restart resumes from the frozen value.
- R7: A timer loaded with 0 never decrements and never raises its irq.
- R8: A write to the count register while a timer runs does not change the running period. It takes effect at the next restart.
- R9: The observer for timer i sits at byte address 0x38+4*i, little-endian. With control bit 2 at 0 it returns the current count. With bit 2 at 1 it returns the bitwise inverse masked to the timer's width.
- R10: A read of observer byte 0 returns the live byte and captures the full observer value. Reads of bytes 1 to 3 return the captured value.
- R11: Read data appears one cycle after rdEn. Addresses outside the map read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Byte write strobe |
| rdEn | input | 1 | Byte read strobe |
| addr | input | AW | Byte address |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, valid one cycle after rdEn |
| irq | output | NT | Per-timer expiry pulse |

## Verification
The bench builds the bank with dividers 3, 5, 7 and 1 for codes 0 to 3. With these values every time base produces many expiries within a few hundred cycles, and the periods of different codes can be told apart by counting pulses. The fast base ticks every cycle, so multi-byte counts can be driven across a byte boundary while a snapshot is taken. The reset-state all-ones counts and the 24-bit truncation are checked directly at the default widths.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  localparam int CNT_W = 32;

  // strobes and settings handed from register control to the counters
  typedef struct packed {
    logic en;
    logic restart;
    logic [1:0] sel;
    logic [CNT_W-1:0] hold;
  } tmrCtl_t;

  function automatic int widthOf(int idx);
    return (idx % 2 == 1) ? 32 : 24;
  endfunction

  function automatic logic [CNT_W-1:0] maskOf(int idx);
    return (widthOf(idx) == 32) ? 32'hFFFF_FFFF : 32'h00FF_FFFF;
  endfunction
endpackage

// File: rtl/cdt_prescaler.sv
module cdt_prescaler #(
  parameter int DIV0 = 244,
  parameter int DIV1 = 7813,
  parameter int DIV2 = 250000,
  parameter int DIV3 = 1
) (
  input  logic       clk,
  input  logic       rstN,
  output logic [3:0] tick
);
  function automatic int divOf(int k);
    case (k)
      0: return DIV0;
      1: return DIV1;
      2: return DIV2;
      default: return DIV3;
    endcase
  endfunction

  for (genvar k = 0; k < 4; k++) begin : g_base
    localparam int D  = divOf(k);
    localparam int PW = $clog2(D) + 1;
    logic [PW-1:0] pc;
    assign tick[k] = (pc == PW'(D - 1));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pc <= '0;
      else if (tick[k]) pc <= '0;
      else pc <= pc + 1'b1;
    end
  end
endmodule

// File: rtl/cdt_regctl.sv
module cdt_regctl
  import cdt_pkg::*;
#(
  parameter int NT = 6,
  parameter int AW = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      wrEn,
  input  logic                      rdEn,
  input  logic [AW-1:0]             addr,
  input  logic [7:0]                wrData,
  output logic [7:0]                rdData,
  input  logic [NT-1:0][CNT_W-1:0]  cntVec,
  output tmrCtl_t [NT-1:0]          ctlVec
);
  localparam int TMR_SPAN = NT * 8;
  localparam int OBS_BASE = 56;
  localparam int OBS_SPAN = NT * 4;

  int aInt, tIdx, tOff, oIdx, oByte;
  logic isTmr, isObs;

  always_comb begin
    aInt  = int'(addr);
    isTmr = aInt < TMR_SPAN;
    isObs = (aInt >= OBS_BASE) && (aInt < OBS_BASE + OBS_SPAN);
    tIdx  = aInt / 8;
    tOff  = aInt % 8;
    oIdx  = (aInt - OBS_BASE) / 4;
    oByte = (aInt - OBS_BASE) % 4;
  end

  logic [NT-1:0]            enV, rsV, cbV;
  logic [NT-1:0][1:0]       selV;
  logic [NT-1:0][CNT_W-1:0] holdV, snapV, obsV;

  for (genvar i = 0; i < NT; i++) begin : g_tmr
    localparam logic [CNT_W-1:0] MASK = maskOf(i);
    logic hit, snapHit;
    logic enR, rsR, cbR;
    logic [1:0] selR;
    logic [CNT_W-1:0] holdR, holdNext, snapR;

    assign hit     = wrEn && isTmr && (tIdx == i);
    assign snapHit = rdEn && isObs && (oIdx == i) && (oByte == 0);

    always_comb begin
      holdNext = holdR;
      case (tOff)
        4: holdNext[7:0]   = wrData;
        5: holdNext[15:8]  = wrData;
        6: holdNext[23:16] = wrData;
        7: holdNext[31:24] = wrData;
        default: ;
      endcase
      holdNext = holdNext & MASK;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        enR   <= 1'b0;
        rsR   <= 1'b0;
        cbR   <= 1'b0;
        selR  <= 2'd0;
        holdR <= MASK;
        snapR <= '0;
      end else begin
        rsR <= hit && (tOff == 0) && wrData[1];
        if (hit && tOff == 0) begin
          enR <= wrData[0];
          cbR <= wrData[2];
        end
        if (hit && tOff == 1) selR <= wrData[1:0];
        if (hit && tOff >= 4) holdR <= holdNext;
        if (snapHit) snapR <= obsV[i];
      end
    end

    assign enV[i]   = enR;
    assign rsV[i]   = rsR;
    assign cbV[i]   = cbR;
    assign selV[i]  = selR;
    assign holdV[i] = holdR;
    assign snapV[i] = snapR;
    assign obsV[i]  = (cbR ? ~cntVec[i] : cntVec[i]) & MASK;
    assign ctlVec[i] = {enR, rsR, selR, holdR};
  end

  logic [7:0] rdNext;
  always_comb begin
    rdNext = 8'h00;
    for (int i = 0; i < NT; i++) begin
      if (isTmr && tIdx == i) begin
        case (tOff)
          0: rdNext = {5'b0, cbV[i], rsV[i], enV[i]};
          1: rdNext = {6'b0, selV[i]};
          4, 5, 6, 7: rdNext = 8'(holdV[i] >> (8 * (tOff - 4)));
          default: rdNext = 8'h00;
        endcase
      end
      if (isObs && oIdx == i) begin
        if (oByte == 0) rdNext = obsV[i][7:0];
        else rdNext = 8'(snapV[i] >> (8 * oByte));
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= 8'h00;
    else if (rdEn) rdData <= rdNext;
  end
endmodule

// File: rtl/cdt_datapath.sv
module cdt_datapath
  import cdt_pkg::*;
#(
  parameter int NT = 6
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [3:0]               tick,
  input  tmrCtl_t [NT-1:0]         ctlVec,
  output logic [NT-1:0][CNT_W-1:0] cntVec,
  output logic [NT-1:0]            irq
);
  for (genvar i = 0; i < NT; i++) begin : g_cnt
    localparam logic [CNT_W-1:0] MASK = maskOf(i);
    logic [CNT_W-1:0] cntR, actR;
    logic irqR, tk;

    assign tk = tick[ctlVec[i].sel];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cntR <= MASK;
        actR <= MASK;
        irqR <= 1'b0;
      end else begin
        irqR <= 1'b0;
        if (ctlVec[i].en && ctlVec[i].restart) begin
          cntR <= ctlVec[i].hold;
          actR <= ctlVec[i].hold;
        end else if (ctlVec[i].en && tk && cntR != '0) begin
          if (cntR == CNT_W'(1)) begin
            cntR <= actR;
            irqR <= 1'b1;
          end else begin
            cntR <= cntR - 1'b1;
          end
        end
      end
    end

    assign cntVec[i] = cntR;
    assign irq[i]    = irqR;
  end
endmodule

// File: rtl/cdt_bank.sv
module cdt_bank
  import cdt_pkg::*;
#(
  parameter int NT       = 6,
  parameter int AW       = 8,
  parameter int DIV_SLOW = 244,
  parameter int DIV_MID  = 7813,
  parameter int DIV_LOW  = 250000,
  parameter int DIV_FAST = 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic          rdEn,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wrData,
  output logic [7:0]    rdData,
  output logic [NT-1:0] irq
);
  logic [3:0]               tick;
  tmrCtl_t [NT-1:0]         ctlVec;
  logic [NT-1:0][CNT_W-1:0] cntVec;

  cdt_prescaler #(
    .DIV0(DIV_SLOW), .DIV1(DIV_MID), .DIV2(DIV_LOW), .DIV3(DIV_FAST)
  ) u_pre (
    .clk(clk), .rstN(rstN), .tick(tick)
  );

  cdt_regctl #(.NT(NT), .AW(AW)) u_ctl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .cntVec(cntVec), .ctlVec(ctlVec)
  );

  cdt_datapath #(.NT(NT)) u_dp (
    .clk(clk), .rstN(rstN), .tick(tick), .ctlVec(ctlVec),
    .cntVec(cntVec), .irq(irq)
  );
endmodule

// File: rtl/cdt_bank_chk.sv
module cdt_bank_chk
  import cdt_pkg::*;
#(
  parameter int NT = 6
) (
  input logic                     clk,
  input logic                     rstN,
  input tmrCtl_t [NT-1:0]         ctlVec,
  input logic [NT-1:0][CNT_W-1:0] cntVec,
  input logic [NT-1:0]            irq
);
  for (genvar i = 0; i < NT; i++) begin : g_chk
    // R4
    irq_source_chk: assert property (@(posedge clk) disable iff (!rstN)
      irq[i] |-> ($past(cntVec[i]) == CNT_W'(1) && $past(ctlVec[i].en)));

    // R7
    zero_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
      (cntVec[i] == '0) |=> !irq[i]);

    // R6
    frozen_count_chk: assert property (@(posedge clk) disable iff (!rstN)
      !ctlVec[i].en |=> $stable(cntVec[i]));

    // R5
    restart_load_chk: assert property (@(posedge clk) disable iff (!rstN)
      (ctlVec[i].en && ctlVec[i].restart) |=> (cntVec[i] == $past(ctlVec[i].hold)));

    if (widthOf(i) == 24) begin : g_narrow
      // R2
      narrow_width_chk: assert property (@(posedge clk) disable iff (!rstN)
        cntVec[i][31:24] == 8'h00);
    end
  end
endmodule

bind cdt_bank cdt_bank_chk #(.NT(NT)) u_chk (
  .clk(clk), .rstN(rstN), .ctlVec(ctlVec), .cntVec(cntVec), .irq(irq)
);

// File: tb/cdt_bank_tb.sv
module cdt_bank_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 6;
  localparam int D0 = 3, D1 = 5, D2 = 7, D3 = 1;
  localparam int WATCHDOG = 50000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [7:0] addr = 8'h00, wrData = 8'h00;
  logic [7:0] rdData;
  logic [NT-1:0] irq;

  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cdt_bank #(.NT(NT), .AW(8), .DIV_SLOW(D0), .DIV_MID(D1), .DIV_LOW(D2),
             .DIV_FAST(D3)) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .irq(irq)
  );

  // ---------------- behavioural reference model ----------------
  int pc[4];
  bit tk[4];
  bit mEn[NT], mRs[NT], mCb[NT], mIrq[NT];
  int mSel[NT];
  logic [31:0] mHold[NT], mAct[NT], mCnt[NT], mSnap[NT];
  logic [7:0] expRd;

  function automatic int divOf(int k);
    return (k == 0) ? D0 : (k == 1) ? D1 : (k == 2) ? D2 : D3;
  endfunction
  function automatic logic [31:0] mask(int i);
    return (i % 2 == 1) ? 32'hFFFF_FFFF : 32'h00FF_FFFF;
  endfunction
  function automatic logic [31:0] obsVal(int i);
    return (mCb[i] ? ~mCnt[i] : mCnt[i]) & mask(i);
  endfunction
  function automatic logic [7:0] mRead(int a);
    logic [31:0] v;
    if (a < NT * 8) begin
      case (a % 8)
        0: return {5'b0, mCb[a/8], mRs[a/8], mEn[a/8]};
        1: return 8'(mSel[a/8]);
        4, 5, 6, 7: begin v = mHold[a/8]; return v[8*(a%8-4) +: 8]; end
        default: return 8'h00;
      endcase
    end else if (a >= 56 && a < 56 + NT * 4) begin
      if ((a - 56) % 4 == 0) begin v = obsVal((a - 56) / 4); return v[7:0]; end
      v = mSnap[(a - 56) / 4];
      return v[8*((a-56)%4) +: 8];
    end
    return 8'h00;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < 4; k++) pc[k] = 0;
      for (int i = 0; i < NT; i++) begin
        mEn[i] = 0; mRs[i] = 0; mCb[i] = 0; mIrq[i] = 0; mSel[i] = 0;
        mHold[i] = mask(i); mAct[i] = mask(i); mCnt[i] = mask(i); mSnap[i] = 0;
      end
    end else begin
      for (int k = 0; k < 4; k++) tk[k] = (pc[k] == divOf(k) - 1);
      for (int k = 0; k < 4; k++) pc[k] = tk[k] ? 0 : pc[k] + 1;
      if (rdEn) begin
        expRd = mRead(int'(addr));
        if (int'(addr) >= 56 && int'(addr) < 56 + NT*4 && (int'(addr) - 56) % 4 == 0)
          mSnap[(int'(addr) - 56) / 4] = obsVal((int'(addr) - 56) / 4);
      end
      for (int i = 0; i < NT; i++) begin
        mIrq[i] = 0;
        if (mEn[i] && mRs[i]) begin
          mCnt[i] = mHold[i]; mAct[i] = mHold[i];
        end else if (mEn[i] && tk[mSel[i]] && mCnt[i] != 0) begin
          if (mCnt[i] == 1) begin mCnt[i] = mAct[i]; mIrq[i] = 1; end
          else mCnt[i] = mCnt[i] - 1;
        end
      end
      for (int i = 0; i < NT; i++) mRs[i] = 0;
      if (wrEn && int'(addr) < NT * 8) begin
        case (int'(addr) % 8)
          0: begin mEn[addr/8] = wrData[0]; mRs[addr/8] = wrData[1]; mCb[addr/8] = wrData[2]; end
          1: mSel[addr/8] = int'(wrData[1:0]);
          4, 5, 6, 7: begin
            mHold[addr/8][8*(int'(addr)%8-4) +: 8] = wrData;
            mHold[addr/8] = mHold[addr/8] & mask(int'(addr)/8);
          end
          default: ;
        endcase
      end
    end
  end

  // per-cycle comparison of the interrupt lines (R4)
  always @(negedge clk) begin
    if (rstN && !done) begin
      logic [NT-1:0] e;
      for (int i = 0; i < NT; i++) e[i] = mIrq[i];
      total++;
      if (irq !== e) begin
        bad++;
        $display("FAIL R4 irq act=%b exp=%b", irq, e);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input int a, input logic [7:0] d);
    addr = 8'(a); wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] v);
    addr = 8'(a); rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
    v = rdData;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic rdModel(input int a, input string req);
    logic [7:0] v;
    rd(a, v);
    check(req, v, expRd);
  endtask

  task automatic rdExp(input int a, input logic [7:0] exp, input string req);
    logic [7:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  task automatic countIrq(input int i, input int n, output int c);
    c = 0;
    repeat (n) begin
      @(negedge clk);
      if (irq[i]) c++;
    end
  endtask

  task automatic loadCount(input int t, input logic [31:0] v);
    for (int b = 0; b < 4; b++) wr(8*t + 4 + b, v[8*b +: 8]);
  endtask

  task automatic finishRun();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    total++; bad++;
    $display("FAIL R11 watchdog act=timeout exp=finished");
    finishRun();
  end

  initial begin
    int c;
    logic [7:0] v0, v1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rdExp(0, 8'h00, "R1 ctrl t0");
    rdExp(1, 8'h00, "R1 sel t0");
    rdExp(8 + 7, 8'hFF, "R1 count t1 byte3");
    rdExp(56, 8'hFF, "R1 obs t0 byte0");
    // R2 24-bit upper byte
    rdExp(7, 8'h00, "R2 count t0 byte3");
    rdExp(59, 8'h00, "R2 obs t0 byte3");
    wr(7, 8'hAB);
    rdExp(7, 8'h00, "R2 t0 byte3 write dropped");
    wr(8 + 7, 8'hAB);
    rdExp(8 + 7, 8'hAB, "R2 t1 byte3 kept");
    // R11 unmapped read
    rdExp(8'h30, 8'h00, "R11 unmapped");

    // R4 fast base, reload 5 on timer1
    loadCount(1, 32'd5);
    wr(8 + 1, 8'd3);
    wr(8, 8'h03);
    // R5 restart bit visible once, then cleared
    rdExp(8, 8'h03, "R5 restart visible");
    rdExp(8, 8'h01, "R5 restart cleared");
    repeat (20) @(negedge clk);
    countIrq(1, 40, c);
    check("R4 period 5 pulses", c, 8);

    // R8 count write while running has no effect until restart
    loadCount(1, 32'd9);
    repeat (20) @(negedge clk);
    countIrq(1, 40, c);
    check("R8 old period kept", c, 8);
    wr(8, 8'h03);
    repeat (20) @(negedge clk);
    countIrq(1, 45, c);
    check("R8 new period after restart", c, 5);

    // R6 disable freezes, resume continues
    wr(8, 8'h00);
    rd(56 + 4, v0);
    check("R6 model obs", v0, expRd);
    repeat (10) @(negedge clk);
    rd(56 + 4, v1);
    check("R6 frozen obs", v1, v0);
    countIrq(1, 20, c);
    check("R6 no irq while off", c, 0);
    wr(8, 8'h01);
    repeat (7) @(negedge clk);
    rdModel(56 + 4, "R6 resumed obs");

    // R3 slow base code 0 (divider 3), reload 2 -> period 6
    wr(8, 8'h00);
    loadCount(3, 32'd2);
    wr(24 + 1, 8'd0);
    wr(24, 8'h03);
    repeat (20) @(negedge clk);
    countIrq(3, 60, c);
    check("R3 code0 pulses", c, 10);
    wr(24, 8'h00);
    // R3 code 2 (divider 7), reload 1 -> period 7
    loadCount(5, 32'd1);
    wr(40 + 1, 8'd2);
    wr(40, 8'h03);
    repeat (20) @(negedge clk);
    countIrq(5, 70, c);
    check("R3 code2 pulses", c, 10);
    // R3 code 1 (divider 5), reload 3 -> period 15
    wr(40 + 1, 8'd1);
    loadCount(5, 32'd3);
    wr(40, 8'h03);
    repeat (20) @(negedge clk);
    countIrq(5, 60, c);
    check("R3 code1 pulses", c, 4);
    wr(40, 8'h00);

    // R7 zero count never fires
    loadCount(2, 32'd0);
    wr(16 + 1, 8'd3);
    wr(16, 8'h03);
    countIrq(2, 40, c);
    check("R7 zero no irq", c, 0);
    rdExp(56 + 8, 8'h00, "R7 obs stays 0");
    wr(16, 8'h00);

    // R9 inverted observer on 24-bit timer0
    loadCount(0, 32'h0000_0010);
    wr(1, 8'd2);
    wr(0, 8'h03);
    wr(0, 8'h00);
    rd(56, v0);
    check("R9 raw obs", v0, expRd);
    wr(0, 8'h04);
    rdExp(56, ~v0, "R9 inverted byte0");
    rdExp(58, 8'hFF, "R9 inverted byte2");
    rdExp(59, 8'h00, "R9 inverted byte3 24-bit");

    // R10 coherent snapshot across byte boundary on timer3
    loadCount(3, 32'h0100_0003);
    wr(24 + 1, 8'd3);
    wr(24, 8'h03);
    rdModel(56 + 12, "R10 byte0 live");
    repeat (3) @(negedge clk);
    rdModel(56 + 12 + 1, "R10 byte1 snap");
    rdModel(56 + 12 + 2, "R10 byte2 snap");
    rdModel(56 + 12 + 3, "R10 byte3 snap");
    wr(24, 8'h00);

    repeat (5) @(negedge clk);
    finishRun();
  end
endmodule